// File: doc/BRIEF.md
# Window Compare and Result Save Filter

This block sits after a signed accumulator in a measurement pipeline. For each accumulated value it decides whether the value falls into a programmed threshold region. It then decides whether a downstream result store should keep that value. The decision combines a comparison mode, which picks one of five regions relative to a low and a high threshold, with a save policy. The save policy keeps the value on every sample, only on a match, only on a miss, or never.

The block consumes one value per cycle, qualified by a single valid strobe. There is no ready signal and no back-pressure: the producer may present a new value on every cycle, and the block never stalls. Each accepted value comes out one clock later as a registered copy. With it come a registered valid, a match flag and a save strobe, so the result store can write directly from these outputs.

Thresholds and modes are plain control inputs sampled together with the value. Changing them between samples takes effect on the next strobed value.

Top module: `window_save_filter`

## Requirements
- R1: After reset, and until the first strobed value, `out_valid`, `out_match` and `out_save` are 0, and `out_result` is 0.
- R2: Comparison mode 0 (off) and the unused codes 5, 6 and 7 never report a match.
- R3: Comparison mode 1 (below) matches when the accumulator is strictly less than `thr_lo`, compared as two's-complement signed numbers. Equality does not match.
- R4: Comparison mode 2 (above) matches when the accumulator is strictly greater than `thr_hi`, compared as signed numbers. Equality does not match.
- R5: Comparison mode 3 (inside) matches when `thr_lo` < accumulator < `thr_hi`, compared as signed numbers. A value equal to either threshold does not match.
- R6: Comparison mode 4 (outside) matches when the accumulator is strictly less than `thr_lo` or strictly greater than `thr_hi`, compared as signed numbers.
- R7: Save mode 0 (all) raises `out_save` for every strobed value.
- R8: Save mode 2 (none) never raises `out_save`.
- R9: Save mode 1 (on match) raises `out_save` exactly when `out_match` is 1. Save mode 3 (on miss) raises it exactly when `out_match` is 0. With comparison off, mode 1 therefore never saves and mode 3 always saves.
- R10: A value strobed by `in_valid` in one cycle appears on `out_result` with `out_valid` high in the next cycle. `out_match` and `out_save` are single-cycle pulses in that same cycle. Without a strobe, all three flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe: `in_acc` holds a value this cycle |
| in_acc | input | DATA_W | Signed accumulated value |
| thr_lo | input | DATA_W | Signed low threshold |
| thr_hi | input | DATA_W | Signed high threshold |
| cmp_mode | input | 3 | Comparison mode: 0 off, 1 below, 2 above, 3 inside, 4 outside, 5-7 treated as off |
| save_mode | input | 2 | Save policy: 0 all, 1 on match, 2 none, 3 on miss |
| out_valid | output | 1 | Registered copy of the strobe |
| out_result | output | DATA_W | Registered copy of the strobed value |
| out_match | output | 1 | Registered match flag for the value on `out_result` |
| out_save | output | 1 | Registered write enable for the result store |

## Verification
The bench builds the block with DATA_W set to 8. This makes the signed extremes -128 and 127 cheap to drive. It also means a comparison done unsigned by mistake gives a visibly wrong answer when a negative value meets a positive threshold. Each mode is driven at values one below, equal to, and one above each threshold. Samples are sent back to back and with gaps, so the pulse alignment and the quiet cycles between strobes are both observed.

// File: rtl/wcf_pkg.sv
package wcf_pkg;

  typedef enum logic [2:0] {
    CMP_OFF     = 3'd0,
    CMP_BELOW   = 3'd1,
    CMP_ABOVE   = 3'd2,
    CMP_INSIDE  = 3'd3,
    CMP_OUTSIDE = 3'd4
  } cmp_mode_e;

  typedef enum logic [1:0] {
    SAVE_ALL   = 2'd0,
    SAVE_MATCH = 2'd1,
    SAVE_NONE  = 2'd2,
    SAVE_MISS  = 2'd3
  } save_mode_e;

  localparam int CMP_MODE_W  = 3;
  localparam int SAVE_MODE_W = 2;

endpackage

// File: rtl/wcf_window_cmp.sv
module wcf_window_cmp
  import wcf_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0]     acc_i,
  input  logic [DATA_W-1:0]     lo_i,
  input  logic [DATA_W-1:0]     hi_i,
  input  logic [CMP_MODE_W-1:0] mode_i,
  output logic                  hit_o
);

  logic below_lo;
  logic above_hi;

  // Both relations are strict and signed; equality never counts.
  assign below_lo = $signed(acc_i) < $signed(lo_i);
  assign above_hi = $signed(acc_i) > $signed(hi_i);

  always_comb begin
    case (mode_i)
      CMP_BELOW:   hit_o = below_lo;
      CMP_ABOVE:   hit_o = above_hi;
      CMP_INSIDE:  hit_o = ($signed(acc_i) > $signed(lo_i)) &&
                           ($signed(acc_i) < $signed(hi_i));
      CMP_OUTSIDE: hit_o = below_lo || above_hi;
      default:     hit_o = 1'b0;  // off and unused codes
    endcase
  end

endmodule

// File: rtl/wcf_save_policy.sv
module wcf_save_policy
  import wcf_pkg::*;
(
  input  logic                   hit_i,
  input  logic [SAVE_MODE_W-1:0] mode_i,
  output logic                   keep_o
);

  always_comb begin
    case (mode_i)
      SAVE_ALL:   keep_o = 1'b1;
      SAVE_MATCH: keep_o = hit_i;
      SAVE_MISS:  keep_o = !hit_i;
      default:    keep_o = 1'b0;  // SAVE_NONE
    endcase
  end

endmodule

// File: rtl/wcf_out_stage.sv
module wcf_out_stage #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              hit_i,
  input  logic              keep_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              hit_o,
  output logic              keep_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      hit_o   <= 1'b0;
      keep_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      hit_o   <= valid_i && hit_i;
      keep_o  <= valid_i && keep_i;
    end
  end

  // Data register only loads on a strobe; holds otherwise.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o <= '0;
    end else if (valid_i) begin
      data_o <= data_i;
    end
  end

endmodule

// File: rtl/window_save_filter.sv
module window_save_filter
  import wcf_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [DATA_W-1:0]      in_acc,
  input  logic [DATA_W-1:0]      thr_lo,
  input  logic [DATA_W-1:0]      thr_hi,
  input  logic [CMP_MODE_W-1:0]  cmp_mode,
  input  logic [SAVE_MODE_W-1:0] save_mode,
  output logic                   out_valid,
  output logic [DATA_W-1:0]      out_result,
  output logic                   out_match,
  output logic                   out_save
);

  logic hit;
  logic keep;

  wcf_window_cmp #(.DATA_W(DATA_W)) u_cmp (
    .acc_i  (in_acc),
    .lo_i   (thr_lo),
    .hi_i   (thr_hi),
    .mode_i (cmp_mode),
    .hit_o  (hit)
  );

  wcf_save_policy u_policy (
    .hit_i  (hit),
    .mode_i (save_mode),
    .keep_o (keep)
  );

  wcf_out_stage #(.DATA_W(DATA_W)) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (in_valid),
    .data_i  (in_acc),
    .hit_i   (hit),
    .keep_i  (keep),
    .valid_o (out_valid),
    .data_o  (out_result),
    .hit_o   (out_match),
    .keep_o  (out_save)
  );

endmodule

// File: rtl/window_save_filter_chk.sv
module window_save_filter_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_acc,
  input logic [DATA_W-1:0] thr_lo,
  input logic [DATA_W-1:0] thr_hi,
  input logic [2:0]        cmp_mode,
  input logic [1:0]        save_mode,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_result,
  input logic              out_match,
  input logic              out_save
);

  assert_flags_need_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_match || out_save) |-> out_valid);

  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_quiet_without_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_result_copy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_result == $past(in_acc));

  assert_off_no_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (cmp_mode == 3'd0 || cmp_mode >= 3'd5)) |=> !out_match);

  assert_below_equal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cmp_mode == 3'd1 && in_acc == thr_lo) |=> !out_match);

  assert_above_equal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cmp_mode == 3'd2 && in_acc == thr_hi) |=> !out_match);

  assert_inside_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cmp_mode == 3'd3 && (in_acc == thr_lo || in_acc == thr_hi)) |=> !out_match);

  assert_save_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && save_mode == 2'd0) |=> out_save);

  assert_save_none_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && save_mode == 2'd2) |=> !out_save);

  assert_save_on_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && save_mode == 2'd1) |=> out_save == out_match);

  assert_save_on_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && save_mode == 2'd3) |=> out_save == !out_match);

endmodule

bind window_save_filter window_save_filter_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_acc     (in_acc),
  .thr_lo     (thr_lo),
  .thr_hi     (thr_hi),
  .cmp_mode   (cmp_mode),
  .save_mode  (save_mode),
  .out_valid  (out_valid),
  .out_result (out_result),
  .out_match  (out_match),
  .out_save   (out_save)
);

// File: tb/window_save_filter_bench.sv
module window_save_filter_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DW         = 8;
  localparam int WDOG       = 20000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_acc = '0;
  logic [DW-1:0] thr_lo = '0;
  logic [DW-1:0] thr_hi = '0;
  logic [2:0]    cmp_mode = '0;
  logic [1:0]    save_mode = '0;
  logic          out_valid;
  logic [DW-1:0] out_result;
  logic          out_match;
  logic          out_save;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [DW-1:0] q_res[$];
  logic          q_match[$];
  logic          q_save[$];
  string         q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  window_save_filter #(.DATA_W(DW)) u_window_save_filter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_acc(in_acc),
    .thr_lo(thr_lo), .thr_hi(thr_hi), .cmp_mode(cmp_mode), .save_mode(save_mode),
    .out_valid(out_valid), .out_result(out_result), .out_match(out_match),
    .out_save(out_save)
  );

  function automatic logic model_match(logic signed [DW-1:0] a, logic signed [DW-1:0] lo,
                                       logic signed [DW-1:0] hi, logic [2:0] cm);
    case (cm)
      3'd1:    return a < lo;
      3'd2:    return a > hi;
      3'd3:    return (a > lo) && (a < hi);
      3'd4:    return (a < lo) || (a > hi);
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic model_save(logic m, logic [1:0] sm);
    case (sm)
      2'd0:    return 1'b1;
      2'd1:    return m;
      2'd3:    return !m;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Driver: presents one strobed value and records what must come out.
  task automatic send(int a, int lo, int hi, int cm, int sm, string tag);
    logic m;
    in_valid  = 1'b1;
    in_acc    = DW'(a);
    thr_lo    = DW'(lo);
    thr_hi    = DW'(hi);
    cmp_mode  = 3'(cm);
    save_mode = 2'(sm);
    m = model_match(DW'(a), DW'(lo), DW'(hi), 3'(cm));
    q_res.push_back(DW'(a));
    q_match.push_back(m);
    q_save.push_back(model_save(m, 2'(sm)));
    q_tag.push_back(tag);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    in_valid = 1'b0;
    in_acc   = 8'h5a;
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops the scoreboard whenever a result appears.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (q_res.size() == 0) begin
          check("R10", "unexpected out_valid", 1, 0);
        end else begin
          string t;
          t = q_tag.pop_front();
          check("R10", "out_result", int'($signed(out_result)), int'($signed(q_res.pop_front())));
          check(t, "out_match", int'(out_match), int'(q_match.pop_front()));
          check((t == "R7" || t == "R8") ? t : "R9", "out_save", int'(out_save),
                int'(q_save.pop_front()));
        end
      end else begin
        check("R10", "idle flags", int'({out_match, out_save}), 0);
      end
    end
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset flags", int'({out_valid, out_match, out_save}), 0);
    check("R1", "reset result", int'(out_result), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "post-reset flags", int'({out_valid, out_match, out_save}), 0);

    // R2: off and unused codes, with save on match / on miss
    send(-100, 0, 0, 0, 1, "R2");
    send(-100, 0, 0, 0, 3, "R2");
    send(-100, 0, 0, 5, 3, "R2");
    send(127,  0, 0, 6, 1, "R2");
    send(50,   0, 0, 7, 0, "R2");
    idle(2);

    // R3: below low threshold, signed and strict
    send(-5,   -4, 0, 1, 1, "R3");
    send(-4,   -4, 0, 1, 1, "R3");
    send(-3,   -4, 0, 1, 1, "R3");
    send(-128, 127, 0, 1, 1, "R3");
    send(127, -128, 0, 1, 1, "R3");
    idle(1);

    // R4: above high threshold
    send(11,   0, 10, 2, 1, "R4");
    send(10,   0, 10, 2, 1, "R4");
    send(-1,   0, 10, 2, 1, "R4");
    send(127,  0, 126, 2, 1, "R4");
    send(-1,   0, -2, 2, 3, "R4");

    // R5: strictly inside
    send(-10, -10, 10, 3, 1, "R5");
    send(-9,  -10, 10, 3, 1, "R5");
    send(0,   -10, 10, 3, 1, "R5");
    send(9,   -10, 10, 3, 1, "R5");
    send(10,  -10, 10, 3, 1, "R5");
    idle(3);

    // R6: outside
    send(-11, -10, 10, 4, 1, "R6");
    send(-10, -10, 10, 4, 1, "R6");
    send(0,   -10, 10, 4, 1, "R6");
    send(10,  -10, 10, 4, 1, "R6");
    send(11,  -10, 10, 4, 1, "R6");

    // R7 / R8 / R9: save policies across hits and misses
    send(20, -10, 10, 4, 0, "R7");
    send(0,  -10, 10, 4, 0, "R7");
    send(20, -10, 10, 4, 2, "R8");
    send(0,  -10, 10, 4, 2, "R8");
    send(20, -10, 10, 4, 3, "R9");
    send(0,  -10, 10, 4, 3, "R9");
    idle(4);

    check("R10", "scoreboard drained", q_res.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule